// File: doc/BRIEF.md
# Radix-4 Twiddle Weighting Stage

This block applies twiddle factors to the four complex results of a radix-4 butterfly. The first lane is never weighted and passes through. Lanes 1, 2 and 3 are each multiplied by a complex coefficient. Each product is formed from four real products, then one subtractor and one adder. The sums are kept at full double precision and only then rounded and saturated to the memory word. The coefficients come from per-lane read-only tables that are computed when the design is elaborated. An extra flag bit stored with each entry marks the entries whose coefficient is unity, and those entries skip the multiplier.

The table address is the low part of the sequencer's master counter. It is captured into an address latch whenever the schedule strobes it, and it holds between strobes. A final-pass control turns weighting off in every lane. A shift control adds one left shift to every result, so the array-scaling logic downstream can renormalise. Data go through one register stage, and the multiply path and the bypass path have the same latency.

Top module: `twiddle_weighter`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` delayed by one clock. A sample's results appear in the cycle that follows its acceptance and stay unchanged until the next accepted sample.
- R2: Lane 0 (bits [DW-1:0] of the input and bits [OW-1:0] of the output) is never multiplied. Its output equals its input times 2^s, where s is `shift_i`.
- R3: For lane k (1..3) with latched address a, the exponent is e = (k·a) mod 256. The coefficient is wr = round(1023·cos(2πe/256)), wi = round(−1023·sin(2πe/256)), with halves rounded away from zero. The raw real sum is vr·wr − vi·wi and the raw imaginary sum is vr·wi + vi·wr.
- R4: A raw sum x is reduced as (x + 2^(9−s)) >>> (10−s), using an arithmetic shift. The result is then saturated to the signed 12-bit range [−2048, 2047].
- R5: A table entry whose exponent is 0 carries the bypass flag. That lane then outputs its input times 2^s exactly, not scaled by 1023/1024.
- R6: A high `addr_load_i` captures `cnt_i` into the address latch at the clock edge. Samples accepted in later cycles use that address. Changes on `cnt_i` without a load have no effect on the results.
- R7: When `final_pass_i` is high with a sample, every lane outputs its input times 2^s.
- R8: `shift_i` applies one extra left shift to both the multiply path and the bypass path of the sample it accompanies.
- R9: While `rst_n` is low, `out_valid_o` and all outputs are 0 and the address latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | AW (6) | Low bits of the master counter |
| addr_load_i | input | 1 | Capture strobe for the coefficient address latch |
| in_valid_i | input | 1 | Butterfly outputs present this cycle |
| final_pass_i | input | 1 | Last iteration: no weighting in any lane |
| shift_i | input | 1 | Conditional left shift by one |
| v_re_i | input | 4·DW (44) | Real parts of lanes 0..3, lane k at [k·DW +: DW] |
| v_im_i | input | 4·DW (44) | Imaginary parts of lanes 0..3 |
| out_valid_o | output | 1 | Weighted results valid |
| y_re_o | output | 4·OW (48) | Real results, lane k at [k·OW +: OW] |
| y_im_o | output | 4·OW (48) | Imaginary results |

## Verification
A wrong address latch shows up as wrong coefficients on lanes 1 to 3 in the first sample after the load or the ignored counter change. The sweep exercises every one of the 64 addresses on three lanes and so reaches every table entry. A fault in the bypass flag, the shift or the rounding offset moves results by at least one LSB in the very next output cycle. Lane 0 and the final-pass runs compare those results exactly. A fault in the valid or hold register shows in the idle cycle after each sample.

// File: rtl/twd_pkg.sv
// Shared helpers for the twiddle weighting stage.
// Assumes: only called with constant arguments, to compute coefficient tables at elaboration.
package twd_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Round a real value to the nearest integer, halves away from zero.
    function automatic int round_away(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    // Quantised real part of exp(-j*2*pi*e/pts).
    function automatic int twd_cos(int e, int pts, int scale);
        return round_away(real'(scale) * $cos(TWO_PI * real'(e) / real'(pts)));
    endfunction

    // Quantised imaginary part of exp(-j*2*pi*e/pts).
    function automatic int twd_nsin(int e, int pts, int scale);
        return round_away(-real'(scale) * $sin(TWO_PI * real'(e) / real'(pts)));
    endfunction

endpackage

// File: rtl/twd_coef_rom.sv
// Coefficient table for one weighted lane.
// Entry i holds W^(LANE*i) on a circle of 4*DEPTH points, with both components
// scaled by 2^(CW-1)-1. It also holds a flag that marks unity entries (exponent 0).
// Assumes: LANE >= 1; the read is combinational from the latched address.
module twd_coef_rom #(
    parameter int AW   = 6,
    parameter int CW   = 11,
    parameter int LANE = 1
) (
    input  logic [AW-1:0]        addr_i,
    output logic signed [CW-1:0] w_re_o,
    output logic signed [CW-1:0] w_im_o,
    output logic                 bypass_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PTS   = 4 * DEPTH;
    localparam int SCALE = (1 << (CW - 1)) - 1;

    logic signed [CW-1:0] tab_re [DEPTH];
    logic signed [CW-1:0] tab_im [DEPTH];
    logic                 tab_flag [DEPTH];

    // Table contents, one entry per generate iteration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam int E   = (LANE * i) % PTS;
        localparam int QRE = twd_pkg::twd_cos(E, PTS, SCALE);
        localparam int QIM = twd_pkg::twd_nsin(E, PTS, SCALE);
        assign tab_re[i]   = CW'(QRE);
        assign tab_im[i]   = CW'(QIM);
        assign tab_flag[i] = (E == 0);
    end

    assign w_re_o   = tab_re[addr_i];
    assign w_im_o   = tab_im[addr_i];
    assign bypass_o = tab_flag[addr_i];

endmodule

// File: rtl/twd_lane.sv
// One complex weighting lane, purely combinational.
// It forms four real products and keeps the add and subtract at full width.
// Then it rounds by 2^-(FRAC-s) and saturates to OW bits. With bypass set,
// the input is aligned by 2^FRAC so that it follows the same rounding path.
// Assumes: FRAC >= 2; OW > DW, so the bypass with shift never saturates.
module twd_lane #(
    parameter int DW   = 11,
    parameter int CW   = 11,
    parameter int OW   = 12,
    parameter int FRAC = 10
) (
    input  logic signed [DW-1:0] v_re_i,
    input  logic signed [DW-1:0] v_im_i,
    input  logic signed [CW-1:0] w_re_i,
    input  logic signed [CW-1:0] w_im_i,
    input  logic                 bypass_i,
    input  logic                 shift_i,
    output logic signed [OW-1:0] y_re_o,
    output logic signed [OW-1:0] y_im_o
);
    localparam int PW = DW + CW + 1;
    localparam logic signed [PW-1:0] HALF0 = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] HALF1 = PW'(1) <<< (FRAC - 2);
    localparam logic signed [PW-1:0] OMAX  = PW'((1 << (OW - 1)) - 1);
    localparam logic signed [PW-1:0] OMIN  = -PW'(1 << (OW - 1));

    logic signed [PW-1:0] vr_x, vi_x, wr_x, wi_x;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [PW-1:0] sum_re, sum_im;

    // Round by the selected shift, then clamp to the output range.
    function automatic logic signed [OW-1:0] reduce(logic signed [PW-1:0] x, logic s);
        logic signed [PW-1:0] r;
        r = s ? ((x + HALF1) >>> (FRAC - 1)) : ((x + HALF0) >>> FRAC);
        if (r > OMAX) return OMAX[OW-1:0];
        if (r < OMIN) return OMIN[OW-1:0];
        return r[OW-1:0];
    endfunction

    assign vr_x = PW'(v_re_i);
    assign vi_x = PW'(v_im_i);
    assign wr_x = PW'(w_re_i);
    assign wi_x = PW'(w_im_i);

    // The four real products, kept at double precision.
    assign p_rr = vr_x * wr_x;
    assign p_ii = vi_x * wi_x;
    assign p_ri = vr_x * wi_x;
    assign p_ir = vi_x * wr_x;

    // Real-to-complex combine, or the aligned bypass value.
    always_comb begin
        if (bypass_i) begin
            sum_re = vr_x <<< FRAC;
            sum_im = vi_x <<< FRAC;
        end else begin
            sum_re = p_rr - p_ii;
            sum_im = p_ri + p_ir;
        end
    end

    assign y_re_o = reduce(sum_re, shift_i);
    assign y_im_o = reduce(sum_im, shift_i);

endmodule

// File: rtl/twiddle_weighter.sv
// Radix-4 twiddle weighting stage.
// Lane 0 passes through. Lanes 1..LANES-1 are weighted by table coefficients,
// read at an address that is latched from the master counter.
// One register stage gives every lane the same one-cycle latency.
// Assumes: LANES = 4 (radix 4); the results register loads only on valid input.
module twiddle_weighter #(
    parameter int DW    = 11,
    parameter int CW    = 11,
    parameter int OW    = 12,
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         cnt_i,
    input  logic                  addr_load_i,
    input  logic                  in_valid_i,
    input  logic                  final_pass_i,
    input  logic                  shift_i,
    input  logic [LANES*DW-1:0]   v_re_i,
    input  logic [LANES*DW-1:0]   v_im_i,
    output logic                  out_valid_o,
    output logic [LANES*OW-1:0]   y_re_o,
    output logic [LANES*OW-1:0]   y_im_o
);
    localparam int FRAC = CW - 1;

    logic [AW-1:0]         addr_q;
    logic [LANES*OW-1:0]   y_re_d, y_im_d;

    // Address latch: capture the counter's low bits on the schedule strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           addr_q <= '0;
        else if (addr_load_i) addr_q <= cnt_i;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [CW-1:0] w_re, w_im;
        logic                 flag;
        logic signed [OW-1:0] lr, li;

        if (k == 0) begin : g_pass
            assign w_re = '0;
            assign w_im = '0;
            assign flag = 1'b1;
        end else begin : g_rom
            twd_coef_rom #(.AW(AW), .CW(CW), .LANE(k)) u_rom (
                .addr_i   (addr_q),
                .w_re_o   (w_re),
                .w_im_o   (w_im),
                .bypass_o (flag)
            );
        end

        twd_lane #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC)) u_lane (
            .v_re_i   ($signed(v_re_i[k*DW +: DW])),
            .v_im_i   ($signed(v_im_i[k*DW +: DW])),
            .w_re_i   (w_re),
            .w_im_i   (w_im),
            .bypass_i (flag | final_pass_i),
            .shift_i  (shift_i),
            .y_re_o   (lr),
            .y_im_o   (li)
        );

        assign y_re_d[k*OW +: OW] = lr;
        assign y_im_d[k*OW +: OW] = li;
    end

    // Result register: load on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            y_re_o      <= '0;
            y_im_o      <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                y_re_o <= y_re_d;
                y_im_o <= y_im_d;
            end
        end
    end

endmodule

// File: rtl/twiddle_weighter_chk.sv
// Assertion checker for twiddle_weighter, attached with bind.
// It tracks the pass-through value each lane should produce and checks valid timing,
// pass-through lanes, zero inputs and output hold.
// Assumes: OW > DW.
module twiddle_weighter_chk #(
    parameter int DW    = 11,
    parameter int OW    = 12,
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid_i,
    input logic                final_pass_i,
    input logic                shift_i,
    input logic [LANES*DW-1:0] v_re_i,
    input logic [LANES*DW-1:0] v_im_i,
    input logic                out_valid_o,
    input logic [LANES*OW-1:0] y_re_o,
    input logic [LANES*OW-1:0] y_im_o
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);                                       // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);                                     // R1
    AST_HOLD_RE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(y_re_o));                                  // R1
    AST_HOLD_IM: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(y_im_o));                                  // R1

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        logic signed [OW-1:0] pass_re_q, pass_im_q;
        logic                 pass_q, zero_q;

        // Remember what this lane must show if the sample passes through.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pass_re_q <= '0;
                pass_im_q <= '0;
                pass_q    <= 1'b0;
                zero_q    <= 1'b0;
            end else begin
                pass_re_q <= OW'($signed(v_re_i[k*DW +: DW])) <<< shift_i;
                pass_im_q <= OW'($signed(v_im_i[k*DW +: DW])) <<< shift_i;
                pass_q    <= (k == 0) || final_pass_i;
                zero_q    <= (v_re_i[k*DW +: DW] == '0) && (v_im_i[k*DW +: DW] == '0);
            end
        end

        AST_LANE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && pass_q) |->
            (y_re_o[k*OW +: OW] == pass_re_q && y_im_o[k*OW +: OW] == pass_im_q)); // R2
        AST_FINAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && pass_q && k != 0) |-> (y_re_o[k*OW +: OW] == pass_re_q)); // R7
        AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && zero_q) |->
            (y_re_o[k*OW +: OW] == '0 && y_im_o[k*OW +: OW] == '0));      // R3
    end

endmodule

bind twiddle_weighter twiddle_weighter_chk #(.DW(DW), .OW(OW), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .final_pass_i (final_pass_i),
    .shift_i      (shift_i),
    .v_re_i       (v_re_i),
    .v_im_i       (v_im_i),
    .out_valid_o  (out_valid_o),
    .y_re_o       (y_re_o),
    .y_im_o       (y_im_o)
);

// File: tb/twiddle_weighter_test.sv
module twiddle_weighter_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 11, OW = 12, AW = 6, L = 4;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] cnt = '0;
    logic addr_load = 1'b0, in_valid = 1'b0, final_pass = 1'b0, shift = 1'b0;
    logic [L*DW-1:0] v_re = '0, v_im = '0;
    logic out_valid;
    logic [L*OW-1:0] y_re, y_im;

    twiddle_weighter uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .addr_load_i(addr_load),
        .in_valid_i(in_valid), .final_pass_i(final_pass), .shift_i(shift),
        .v_re_i(v_re), .v_im_i(v_im), .out_valid_o(out_valid),
        .y_re_o(y_re), .y_im_o(y_im)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int pr[L], pi[L];
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic int sat12(longint x);
        if (x > 2047) return 2047;
        if (x < -2048) return -2048;
        return int'(x);
    endfunction

    // Expected lane result from the requirements (im selects the component).
    function automatic int expect_lane(int k, int a, bit s, bit fin, bit im);
        int e, wr, wi;
        longint x;
        e  = (k * a) % 256;
        wr = rnd(1023.0 * $cos(TWO_PI * real'(e) / 256.0));
        wi = rnd(-1023.0 * $sin(TWO_PI * real'(e) / 256.0));
        if (k == 0 || fin || e == 0)
            x = longint'(im ? pi[k] : pr[k]) * 1024;
        else if (!im)
            x = longint'(pr[k]) * wr - longint'(pi[k]) * wi;
        else
            x = longint'(pr[k]) * wi + longint'(pi[k]) * wr;
        return sat12((x + (s ? 256 : 512)) >>> (s ? 9 : 10));
    endfunction

    task automatic check(string req, string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int lane_out(logic [L*OW-1:0] bus, int k);
        return int'($signed(bus[k*OW +: OW]));
    endfunction

    function automatic int rand_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % 2048) - 1024;
    endfunction

    task automatic load_addr(int a);
        @(negedge clk);
        cnt = AW'(a);
        addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        cnt = AW'(a + 23);   // R6: counter moves on without a load
    endtask

    // Send pr/pi as one sample, check all lanes, then check the idle cycle.
    task automatic send(int a, bit s, bit fin, string tag);
        logic [L*OW-1:0] hold_re, hold_im;
        @(negedge clk);
        for (int k = 0; k < L; k++) begin
            v_re[k*DW +: DW] = DW'(pr[k]);
            v_im[k*DW +: DW] = DW'(pi[k]);
        end
        in_valid = 1'b1; shift = s; final_pass = fin;
        cnt = cnt + 1'b1;
        @(negedge clk);
        in_valid = 1'b0; final_pass = 1'b0; shift = 1'b0;
        check("R1", "valid after sample", int'(out_valid), 1);
        for (int k = 0; k < L; k++) begin
            string req;
            req = fin ? "R7" : (k == 0) ? "R2" : (a == 0) ? "R5" : tag;
            check(req, $sformatf("lane%0d re a=%0d", k, a), lane_out(y_re, k), expect_lane(k, a, s, fin, 1'b0));
            check(req, $sformatf("lane%0d im a=%0d", k, a), lane_out(y_im, k), expect_lane(k, a, s, fin, 1'b1));
        end
        hold_re = y_re; hold_im = y_im;
        v_re = '0; v_im = '0;
        @(negedge clk);
        check("R1", "valid idle", int'(out_valid), 0);
        check("R1", "hold", int'(y_re == hold_re && y_im == hold_im), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "valid in reset", int'(out_valid), 0);
        check("R9", "outputs in reset", int'(y_re == '0 && y_im == '0), 1);
        rst_n = 1'b1;
        // R9: address latch resets to 0 (all lanes bypass)
        for (int k = 0; k < L; k++) begin pr[k] = rand_val(); pi[k] = rand_val(); end
        send(0, 1'b0, 1'b0, "R9");

        // Sweep every address with four patterns.
        for (int a = 0; a < (1 << AW); a++) begin
            load_addr(a);
            for (int k = 0; k < L; k++) begin pr[k] = rand_val(); pi[k] = rand_val(); end
            send(a, 1'b0, 1'b0, "R3");
            for (int k = 0; k < L; k++) begin pr[k] = rand_val(); pi[k] = rand_val(); end
            send(a, 1'b1, 1'b0, "R8");
            for (int k = 0; k < L; k++) begin pr[k] = -1024; pi[k] = -1024; end
            send(a, 1'b1, 1'b0, "R4");
            for (int k = 0; k < L; k++) begin pr[k] = 1023; pi[k] = -1024; end
            send(a, 1'b0, 1'b0, "R6");
        end

        // R7: final pass at several addresses, with and without shift.
        for (int i = 0; i < 3; i++) begin
            int a;
            a = (i == 0) ? 1 : (i == 1) ? 21 : 63;
            load_addr(a);
            for (int k = 0; k < L; k++) begin pr[k] = rand_val(); pi[k] = rand_val(); end
            send(a, i[0], 1'b1, "R7");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule